// File: doc/BRIEF.md
# Per-CPU Highest Priority Interrupt Selector

This block sits between an interrupt state store and the CPUs of a multiprocessor. For every CPU it scans all interrupt IDs, private ones and shared ones alike, and picks the most urgent interrupt that CPU may take. It then decides whether that CPU's interrupt request line should be high. The state store supplies the enable, pending, active, priority and routing vectors. Each CPU has its own bank of private interrupts, IDs 0 to 31, carrying their own pending, active and priority state. Shared interrupts, from ID 32 upward, are held once and are routed to CPUs through a per-interrupt target mask.

A smaller priority number means a more urgent interrupt. The search starts from the all-ones value, and a candidate replaces the current best only when its value is strictly smaller. When two candidates tie, the one with the lower ID is kept. The request is gated by a global distributor enable, a per-CPU interface enable, a per-CPU priority mask and the active state of the winner. For every CPU the winner ID, the winner priority and the request are registered once per clock.

Top module: `hps_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, every CPU reports winner ID 1023, winner priority 0xFF and a low request.
- R2: A lower priority value beats a higher one. A pending interrupt whose priority is 0xFF can never win, because the search starts at 0xFF and needs a strictly smaller value.
- R3: Among candidates of equal priority, the lowest ID wins. IDs 0–15 are scanned first, then 16–31, then shared IDs in ascending order.
- R4: A shared interrupt (ID 32 and above) is a candidate only when both its enable bit and its pending bit are set.
- R5: Private IDs 0–31 use the evaluated CPU's own banked pending, active and priority slices. A private interrupt is a candidate whenever its banked pending bit is set; no enable bit applies to it.
- R6: When `multi_cpu` is high, a shared interrupt is a candidate for CPU c only if bit c of its `NUM_CPU`-bit target field is set. When `multi_cpu` is low, the target field is ignored.
- R7: A CPU's request is high only when `dist_en` is high, that CPU's `cpu_if_en` bit is high, a winner exists and the winner's priority is strictly below that CPU's mask byte.
- R8: If the winner's active bit is set, the request stays low, but the winner ID and priority are still reported.
- R9: With no candidate, the winner ID is 1023, the priority is 0xFF and the request is low.
- R10: Outputs reflect the inputs present at the previous rising clock edge, with exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global distributor enable |
| multi_cpu | input | 1 | High when more than one CPU is running; turns on target checking |
| cpu_if_en | input | NUM_CPU | Per-CPU interface enable |
| cpu_pmr | input | NUM_CPU*8 | Per-CPU priority mask, byte c for CPU c |
| priv_pend | input | NUM_CPU*32 | Banked pending bits, CPU c in bits [c*32+31:c*32] |
| priv_act | input | NUM_CPU*32 | Banked active bits, same layout |
| priv_prio | input | NUM_CPU*256 | Banked priorities, byte (c*32+i) for CPU c, ID i |
| sh_en | input | NUM_IRQ-32 | Shared enable, bit j for ID 32+j |
| sh_pend | input | NUM_IRQ-32 | Shared pending, bit j for ID 32+j |
| sh_act | input | NUM_IRQ-32 | Shared active, bit j for ID 32+j |
| sh_prio | input | (NUM_IRQ-32)*8 | Shared priority, byte j for ID 32+j |
| sh_tgt | input | (NUM_IRQ-32)*NUM_CPU | Target mask, bit j*NUM_CPU+c routes ID 32+j to CPU c |
| win_id | output | NUM_CPU*10 | Registered winner ID per CPU, 1023 when none |
| win_prio | output | NUM_CPU*8 | Registered winner priority per CPU |
| irq_req | output | NUM_CPU | Registered interrupt request per CPU |

## Verification
The selection is combinational up to a single output register, so any fault in candidate qualification, tie breaking or gating appears at `win_id`, `win_prio` or `irq_req` on the very next clock edge after the inputs that expose it. A wrong target column or banked slice shows up as one CPU reporting a winner that belongs to another CPU, or reporting 1023 where a winner exists. A reversed tie rule shows up as a higher ID winning among equal priorities. An off-by-one in either priority comparison shows up in the two boundary cases: a pending priority of 0xFF, and a winner priority equal to the mask.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int PRIO_W   = 8;
    localparam int ID_W     = 10;
    localparam int PRIV_N   = 32;
    localparam int SPURIOUS = 1023;

    typedef struct packed {
        logic              valid;
        logic              act;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    function automatic cand_t no_cand();
        cand_t r;
        r.valid = 1'b0;
        r.act   = 1'b0;
        r.id    = ID_W'(SPURIOUS);
        r.prio  = '1;
        return r;
    endfunction

    // lower-index operand a keeps the slot on equal priority
    function automatic cand_t pick(cand_t a, cand_t b);
        if (b.valid && (!a.valid || (b.prio < a.prio)))
            return b;
        return a;
    endfunction
endpackage

// File: rtl/hps_gather.sv
module hps_gather
    import hps_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                          multi_cpu,
    input  logic [PRIV_N-1:0]             priv_pend,
    input  logic [PRIV_N-1:0]             priv_act,
    input  logic [PRIV_N*PRIO_W-1:0]      priv_prio,
    input  logic [NUM_IRQ-PRIV_N-1:0]     sh_en,
    input  logic [NUM_IRQ-PRIV_N-1:0]     sh_pend,
    input  logic [NUM_IRQ-PRIV_N-1:0]     sh_act,
    input  logic [(NUM_IRQ-PRIV_N)*PRIO_W-1:0] sh_prio,
    input  logic [NUM_IRQ-PRIV_N-1:0]     tgt_col,
    output cand_t [NUM_IRQ-1:0]           leaf
);
    localparam int NSH = NUM_IRQ - PRIV_N;

    always_comb begin
        for (int i = 0; i < PRIV_N; i++) begin
            leaf[i].prio  = priv_prio[i*PRIO_W +: PRIO_W];
            leaf[i].act   = priv_act[i];
            leaf[i].id    = ID_W'(i);
            leaf[i].valid = priv_pend[i] &&
                            (priv_prio[i*PRIO_W +: PRIO_W] != {PRIO_W{1'b1}});
        end
        for (int j = 0; j < NSH; j++) begin
            leaf[PRIV_N+j].prio  = sh_prio[j*PRIO_W +: PRIO_W];
            leaf[PRIV_N+j].act   = sh_act[j];
            leaf[PRIV_N+j].id    = ID_W'(PRIV_N + j);
            leaf[PRIV_N+j].valid = sh_en[j] && sh_pend[j] &&
                                   (!multi_cpu || tgt_col[j]) &&
                                   (sh_prio[j*PRIO_W +: PRIO_W] != {PRIO_W{1'b1}});
        end
    end
endmodule

// File: rtl/hps_tree.sv
module hps_tree
    import hps_pkg::*;
#(
    parameter int N = 64
) (
    input  cand_t [N-1:0] leaf,
    output cand_t         best
);
    localparam int LG     = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << LG;

    for (genvar l = 0; l <= LG; l++) begin : lv
        localparam int W = LEAVES >> l;
        cand_t [W-1:0] nodes;
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_i
                if (i < N) begin : g_real
                    assign nodes[i] = leaf[i];
                end else begin : g_pad
                    assign nodes[i] = no_cand();
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_i
                assign nodes[i] = pick(lv[l-1].nodes[2*i], lv[l-1].nodes[2*i+1]);
            end
        end
    end

    assign best = lv[LG].nodes[0];
endmodule

// File: rtl/hps_irq_gate.sv
module hps_irq_gate
    import hps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dist_en,
    input  logic              if_en,
    input  logic [PRIO_W-1:0] pmr,
    input  cand_t             best,
    output logic [ID_W-1:0]   win_id,
    output logic [PRIO_W-1:0] win_prio,
    output logic              irq
);
    logic fire;
    assign fire = dist_en && if_en && best.valid && (best.prio < pmr) && !best.act;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_id   <= ID_W'(SPURIOUS);
            win_prio <= '1;
            irq      <= 1'b0;
        end else if (best.valid) begin
            win_id   <= best.id;
            win_prio <= best.prio;
            irq      <= fire;
        end else begin
            win_id   <= ID_W'(SPURIOUS);
            win_prio <= '1;
            irq      <= 1'b0;
        end
    end
endmodule

// File: rtl/hps_arbiter.sv
module hps_arbiter
    import hps_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   dist_en,
    input  logic                                   multi_cpu,
    input  logic [NUM_CPU-1:0]                     cpu_if_en,
    input  logic [NUM_CPU*8-1:0]                   cpu_pmr,
    input  logic [NUM_CPU*32-1:0]                  priv_pend,
    input  logic [NUM_CPU*32-1:0]                  priv_act,
    input  logic [NUM_CPU*32*8-1:0]                priv_prio,
    input  logic [NUM_IRQ-32-1:0]                  sh_en,
    input  logic [NUM_IRQ-32-1:0]                  sh_pend,
    input  logic [NUM_IRQ-32-1:0]                  sh_act,
    input  logic [(NUM_IRQ-32)*8-1:0]              sh_prio,
    input  logic [(NUM_IRQ-32)*NUM_CPU-1:0]        sh_tgt,
    output logic [NUM_CPU*10-1:0]                  win_id,
    output logic [NUM_CPU*8-1:0]                   win_prio,
    output logic [NUM_CPU-1:0]                     irq_req
);
    localparam int NSH = NUM_IRQ - PRIV_N;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NSH-1:0]       tgt_col;
        cand_t [NUM_IRQ-1:0]  leaf;
        cand_t                best;

        always_comb begin
            for (int j = 0; j < NSH; j++)
                tgt_col[j] = sh_tgt[j*NUM_CPU + c];
        end

        hps_gather #(.NUM_IRQ(NUM_IRQ)) u_gather (
            .multi_cpu (multi_cpu),
            .priv_pend (priv_pend[c*PRIV_N +: PRIV_N]),
            .priv_act  (priv_act[c*PRIV_N +: PRIV_N]),
            .priv_prio (priv_prio[c*PRIV_N*PRIO_W +: PRIV_N*PRIO_W]),
            .sh_en     (sh_en),
            .sh_pend   (sh_pend),
            .sh_act    (sh_act),
            .sh_prio   (sh_prio),
            .tgt_col   (tgt_col),
            .leaf      (leaf)
        );

        hps_tree #(.N(NUM_IRQ)) u_tree (
            .leaf (leaf),
            .best (best)
        );

        hps_irq_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .dist_en  (dist_en),
            .if_en    (cpu_if_en[c]),
            .pmr      (cpu_pmr[c*PRIO_W +: PRIO_W]),
            .best     (best),
            .win_id   (win_id[c*ID_W +: ID_W]),
            .win_prio (win_prio[c*PRIO_W +: PRIO_W]),
            .irq      (irq_req[c])
        );
    end
endmodule

// File: rtl/hps_arbiter_chk.sv
module hps_arbiter_chk #(
    parameter int NUM_CPU = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 dist_en,
    input logic [NUM_CPU-1:0]   cpu_if_en,
    input logic [NUM_CPU*8-1:0] cpu_pmr,
    input logic [NUM_CPU*10-1:0] win_id,
    input logic [NUM_CPU*8-1:0] win_prio,
    input logic [NUM_CPU-1:0]   irq_req
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (rst)
            (win_id[c*10 +: 10] == 10'd1023) |-> (win_prio[c*8 +: 8] == 8'hFF && !irq_req[c])); // R9
        AST_NO_FF_WINNER: assert property (@(posedge clk) disable iff (rst)
            (win_id[c*10 +: 10] != 10'd1023) |-> (win_prio[c*8 +: 8] != 8'hFF)); // R2
        AST_DIST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
            !dist_en |=> !irq_req[c]); // R7
        AST_IF_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
            !cpu_if_en[c] |=> !irq_req[c]); // R7
        AST_BELOW_MASK: assert property (@(posedge clk) disable iff (rst)
            irq_req[c] |-> (win_prio[c*8 +: 8] < $past(cpu_pmr[c*8 +: 8]))); // R7
    end
endmodule

bind hps_arbiter hps_arbiter_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dist_en   (dist_en),
    .cpu_if_en (cpu_if_en),
    .cpu_pmr   (cpu_pmr),
    .win_id    (win_id),
    .win_prio  (win_prio),
    .irq_req   (irq_req)
);

// File: tb/hps_arbiter_tb.sv
`timescale 1ns/1ps
module hps_arbiter_tb;
    localparam int NC  = 2;
    localparam int NI  = 64;
    localparam int NS  = NI - 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dist_en, multi_cpu;
    logic [NC-1:0]      cpu_if_en;
    logic [NC*8-1:0]    cpu_pmr;
    logic [NC*32-1:0]   priv_pend, priv_act;
    logic [NC*256-1:0]  priv_prio;
    logic [NS-1:0]      sh_en, sh_pend, sh_act;
    logic [NS*8-1:0]    sh_prio;
    logic [NS*NC-1:0]   sh_tgt;
    logic [NC*10-1:0]   win_id;
    logic [NC*8-1:0]    win_prio;
    logic [NC-1:0]      irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hps_arbiter #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input int c, output int id, output int pr, output bit irq);
        int best; bit a; bit cand; int p; bit pa;
        best = 255; id = 1023; a = 1'b0;
        for (int i = 0; i < NI; i++) begin
            if (i < 32) begin
                cand = priv_pend[c*32+i];
                p    = priv_prio[(c*32+i)*8 +: 8];
                pa   = priv_act[c*32+i];
            end else begin
                cand = sh_en[i-32] && sh_pend[i-32] && (!multi_cpu || sh_tgt[(i-32)*NC+c]);
                p    = sh_prio[(i-32)*8 +: 8];
                pa   = sh_act[i-32];
            end
            if (cand && p < best) begin
                best = p; id = i; a = pa;
            end
        end
        pr  = best;
        irq = (id != 1023) && dist_en && cpu_if_en[c] && (best < cpu_pmr[c*8 +: 8]) && !a;
    endtask

    task automatic check_all(input string rid, input string rpr, input string rirq);
        int id, pr; bit irq;
        for (int c = 0; c < NC; c++) begin
            model(c, id, pr, irq);
            chk(win_id[c*10 +: 10] == id, rid, int'(win_id[c*10 +: 10]), id);
            chk(win_prio[c*8 +: 8] == pr, rpr, int'(win_prio[c*8 +: 8]), pr);
            chk(irq_req[c] == irq, rirq, int'(irq_req[c]), int'(irq));
        end
    endtask

    task automatic clear_all();
        dist_en = 1'b1; multi_cpu = 1'b0; cpu_if_en = '1; cpu_pmr = {NC{8'hF0}};
        priv_pend = '0; priv_act = '0; priv_prio = '0;
        sh_en = '0; sh_pend = '0; sh_act = '0; sh_prio = '0; sh_tgt = '0;
    endtask

    // inputs already set at a negedge; let one posedge register them
    task automatic step(input string rid, input string rpr, input string rirq);
        @(negedge clk);
        check_all(rid, rpr, rirq);
    endtask

    task automatic set_sh(input int id, input int pr);
        sh_en[id-32] = 1'b1; sh_pend[id-32] = 1'b1; sh_prio[(id-32)*8 +: 8] = pr[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        clear_all();
        priv_pend = '1; sh_en = '1; sh_pend = '1;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NC; c++) begin
            chk(win_id[c*10 +: 10] == 1023, "R1", int'(win_id[c*10 +: 10]), 1023);
            chk(win_prio[c*8 +: 8] == 8'hFF, "R1", int'(win_prio[c*8 +: 8]), 255);
            chk(!irq_req[c], "R1", int'(irq_req[c]), 0);
        end
        clear_all();
        rst = 1'b0;
        @(negedge clk);
        chk(win_id[9:0] == 1023, "R1", int'(win_id[9:0]), 1023);

        // R9 nothing pending
        step("R9", "R9", "R9");

        // R4 + R6 single-CPU: target ignored
        set_sh(40, 8'h20);
        step("R6", "R4", "R7");
        chk(win_id[19:10] == 40, "R6", int'(win_id[19:10]), 40);
        // R4 pending without enable
        sh_en[8] = 1'b0;
        step("R4", "R4", "R4");
        chk(win_id[9:0] == 1023, "R4", int'(win_id[9:0]), 1023);

        // R2 lower value wins
        clear_all(); set_sh(40, 8'h30); set_sh(50, 8'h10);
        step("R2", "R2", "R7");
        chk(win_id[9:0] == 50, "R2", int'(win_id[9:0]), 50);
        // R2 priority 0xFF never wins
        clear_all(); set_sh(41, 8'hFF); priv_pend[3] = 1'b1; priv_prio[3*8 +: 8] = 8'hFF;
        step("R2", "R2", "R2");
        chk(win_id[9:0] == 1023, "R2", int'(win_id[9:0]), 1023);

        // R3 ties: lowest ID wins
        clear_all(); set_sh(35, 8'h10); set_sh(60, 8'h10);
        step("R3", "R3", "R3");
        chk(win_id[9:0] == 35, "R3", int'(win_id[9:0]), 35);
        priv_pend[20] = 1'b1; priv_prio[20*8 +: 8] = 8'h10;
        step("R3", "R3", "R3");
        chk(win_id[9:0] == 20, "R3", int'(win_id[9:0]), 20);
        priv_pend[3] = 1'b1; priv_prio[3*8 +: 8] = 8'h10;
        step("R3", "R3", "R3");
        chk(win_id[9:0] == 3, "R3", int'(win_id[9:0]), 3);

        // R5 banked private state
        clear_all(); priv_pend[5] = 1'b1; priv_prio[5*8 +: 8] = 8'h40;
        priv_pend[32+7] = 1'b1; priv_prio[(32+7)*8 +: 8] = 8'h60; priv_prio[(32+5)*8 +: 8] = 8'h01;
        step("R5", "R5", "R5");
        chk(win_id[9:0] == 5 && win_id[19:10] == 7, "R5", int'(win_id[19:10]), 7);

        // R6 multi-CPU targeting
        clear_all(); multi_cpu = 1'b1; set_sh(45, 8'h22); sh_tgt[(45-32)*NC+1] = 1'b1;
        step("R6", "R6", "R6");
        chk(win_id[9:0] == 1023 && win_id[19:10] == 45, "R6", int'(win_id[9:0]), 1023);

        // R7 gating boundaries
        clear_all(); set_sh(33, 8'h50); cpu_pmr[7:0] = 8'h50;
        step("R7", "R7", "R7");
        chk(!irq_req[0], "R7", int'(irq_req[0]), 0);
        cpu_pmr[7:0] = 8'h51;
        step("R7", "R7", "R7");
        chk(irq_req[0], "R7", int'(irq_req[0]), 1);
        dist_en = 1'b0;
        step("R7", "R7", "R7");
        dist_en = 1'b1; cpu_if_en[0] = 1'b0;
        step("R7", "R7", "R7");

        // R8 active winner reported without request
        clear_all(); set_sh(45, 8'h08); sh_act[45-32] = 1'b1;
        step("R8", "R8", "R8");
        chk(win_id[9:0] == 45 && !irq_req[0], "R8", int'(irq_req[0]), 0);

        // R10 one register stage
        clear_all(); set_sh(34, 8'h10);
        @(negedge clk);
        set_sh(33, 8'h05);
        #1;
        chk(win_id[9:0] == 34, "R10", int'(win_id[9:0]), 34);
        @(posedge clk); #1;
        chk(win_id[9:0] == 33, "R10", int'(win_id[9:0]), 33);

        // random mix
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            dist_en   = ($urandom % 8) != 0;
            multi_cpu = $urandom % 2;
            cpu_if_en = NC'($urandom);
            for (int c = 0; c < NC; c++) cpu_pmr[c*8 +: 8] = 8'($urandom);
            for (int w = 0; w < NC; w++) begin
                priv_pend[w*32 +: 32] = $urandom & $urandom & $urandom;
                priv_act[w*32 +: 32]  = $urandom & $urandom;
            end
            for (int k = 0; k < NC*32; k++) priv_prio[k*8 +: 8] = 8'($urandom % 4 == 0 ? 8'hFF : $urandom % 64);
            sh_en   = NS'({$urandom, $urandom});
            sh_pend = NS'({$urandom, $urandom} & {$urandom, $urandom});
            sh_act  = NS'({$urandom, $urandom} & {$urandom, $urandom});
            sh_tgt  = (NS*NC)'({$urandom, $urandom});
            for (int k = 0; k < NS; k++) sh_prio[k*8 +: 8] = 8'($urandom % 64);
            @(negedge clk);
            check_all("R3", "R2", "R7");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule